// File: doc/BRIEF.md
# Single-Operand Shift/Modify Unit

This combinational unit does the arithmetic step of a read-modify-write operation on one operand. A 4-bit operation code selects the operation: negate, complement, shifts, rotates through carry, increment, decrement, test, swap or clear. The unit returns the new operand value, a write-back enable and the updated N, Z, C and V condition flags. Fetching the operand and writing it back are done by the surrounding sequencer, which uses the write-back enable to decide whether a store follows.

The unit works on an 8-bit operand by default. A word-mode input switches it to a 16-bit operand, for the forms that work on index registers. In byte mode only the low byte of the operand input is used, and the high byte of the result is zero.

Top module: `sm_unit`

## Requirements
- R1: The flag bus is ordered [3]=N, [2]=Z, [1]=C, [0]=V on both input and output. For every legal code, N equals the result's most significant bit (bit 7 in byte mode, bit 15 in word mode) and Z is 1 exactly when the result is zero. In byte mode the result's bits [15:8] are 0 and operand bits [15:8] have no effect.
- R2: Code 0x0 gives the two's-complement negation. C is set when the operand is nonzero. V is set when the operand is the most negative value (0x80 or 0x8000).
- R3: Code 0x3 gives the bitwise inverse of the operand. C is set to 1 and V is kept.
- R4: Code 0x4 shifts right and brings in a zero at the MSB. Code 0x7 shifts right and keeps the MSB. Both send the old LSB to C and keep V.
- R5: Code 0x6 rotates right through carry (the old C enters the MSB, the old LSB goes to C). Code 0x9 rotates left through carry (the old C enters the LSB, the old MSB goes to C). V is kept.
- R6: Code 0x8 shifts left, brings in a zero at the LSB and sends the old MSB to C. V is kept.
- R7: Code 0xA decrements and code 0xC increments. C is kept. V is set on signed overflow: decrement of 0x80/0x8000, or increment of 0x7F/0x7FFF.
- R8: Code 0xD returns the operand unchanged with write-back enable 0. C and V are kept.
- R9: Code 0xE swaps the two 4-bit halves in byte mode and the two bytes in word mode. C and V are kept.
- R10: Code 0xF returns zero, clears N and sets Z. C and V are kept.
- R11: Codes 0x1, 0x2, 0x5 and 0xB give write-back enable 0 and a zero result, and the output flags equal the input flags.
- R12: With word mode set, every legal code works on all 16 operand bits. The write-back enable is 1 for every legal code except 0xD, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 16 | Operand; only bits [7:0] are used in byte mode |
| code_i | input | 4 | Operation code |
| word_i | input | 1 | 1 selects the 16-bit operand width |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| res_o | output | 16 | Result value |
| wr_o | output | 1 | Write-back enable |
| flags_o | output | 4 | Updated flags {N,Z,C,V} |

## Verification
The unit has no registers, so every output is due in the same cycle its inputs change. The bench drives each new input set one nanosecond after a rising clock edge and reads the result, the write-back enable and the flags at the following falling edge, half a period later, when all logic has settled. No check looks ahead to a later cycle.

// File: rtl/sm_pkg.sv
package sm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_NEG = 4'h0,
        OP_CPL = 4'h3,
        OP_SRL = 4'h4,
        OP_RRC = 4'h6,
        OP_SRA = 4'h7,
        OP_SLL = 4'h8,
        OP_RLC = 4'h9,
        OP_DEC = 4'hA,
        OP_INC = 4'hC,
        OP_TNZ = 4'hD,
        OP_SWP = 4'hE,
        OP_CLR = 4'hF
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flag_t;

    function automatic logic code_is_legal(input logic [CODE_W-1:0] code);
        case (code)
            4'h1, 4'h2, 4'h5, 4'hB: code_is_legal = 1'b0;
            default:                code_is_legal = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sm_decode.sv
module sm_decode
    import sm_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o,
    output logic              wr_o
);
    always_comb begin
        legal_o = code_is_legal(code_i);
        wr_o    = legal_o && (code_i != OP_TNZ);
    end
endmodule

// File: rtl/sm_core.sv
module sm_core
    import sm_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]      a_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              cin_i,
    output logic [W-1:0]      r_o,
    output logic              c_new_o,
    output logic              c_upd_o,
    output logic              v_new_o,
    output logic              v_upd_o
);
    localparam int unsigned HALF = W / 2;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        r_o     = '0;
        c_new_o = 1'b0;
        c_upd_o = 1'b0;
        v_new_o = 1'b0;
        v_upd_o = 1'b0;
        case (op_e'(code_i))
            OP_NEG: begin
                r_o     = '0 - a_i;
                c_new_o = (a_i != '0);
                c_upd_o = 1'b1;
                v_new_o = (a_i == MIN_NEG);
                v_upd_o = 1'b1;
            end
            OP_CPL: begin
                r_o     = ~a_i;
                c_new_o = 1'b1;
                c_upd_o = 1'b1;
            end
            OP_SRL: begin
                r_o     = {1'b0, a_i[W-1:1]};
                c_new_o = a_i[0];
                c_upd_o = 1'b1;
            end
            OP_RRC: begin
                r_o     = {cin_i, a_i[W-1:1]};
                c_new_o = a_i[0];
                c_upd_o = 1'b1;
            end
            OP_SRA: begin
                r_o     = {a_i[W-1], a_i[W-1:1]};
                c_new_o = a_i[0];
                c_upd_o = 1'b1;
            end
            OP_SLL: begin
                r_o     = {a_i[W-2:0], 1'b0};
                c_new_o = a_i[W-1];
                c_upd_o = 1'b1;
            end
            OP_RLC: begin
                r_o     = {a_i[W-2:0], cin_i};
                c_new_o = a_i[W-1];
                c_upd_o = 1'b1;
            end
            OP_DEC: begin
                r_o     = a_i - ONE;
                v_new_o = (a_i == MIN_NEG);
                v_upd_o = 1'b1;
            end
            OP_INC: begin
                r_o     = a_i + ONE;
                v_new_o = (a_i == MAX_POS);
                v_upd_o = 1'b1;
            end
            OP_TNZ: r_o = a_i;
            OP_SWP: r_o = {a_i[HALF-1:0], a_i[W-1:HALF]};
            OP_CLR: r_o = '0;
            default: r_o = '0;
        endcase
    end
endmodule

// File: rtl/sm_flags.sv
module sm_flags
    import sm_pkg::*;
(
    input  logic              legal_i,
    input  logic              word_i,
    input  logic [WORD_W-1:0] res_i,
    input  logic              c_new_i,
    input  logic              c_upd_i,
    input  logic              v_new_i,
    input  logic              v_upd_i,
    input  flag_t             flags_i,
    output flag_t             flags_o
);
    always_comb begin
        flags_o = flags_i;
        if (legal_i) begin
            flags_o.n = word_i ? res_i[WORD_W-1] : res_i[BYTE_W-1];
            flags_o.z = (res_i == '0);
            if (c_upd_i) flags_o.c = c_new_i;
            if (v_upd_i) flags_o.v = v_new_i;
        end
    end
endmodule

// File: rtl/sm_unit.sv
module sm_unit
    import sm_pkg::*;
(
    input  logic [WORD_W-1:0] opnd_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              word_i,
    input  logic [3:0]        flags_i,
    output logic [WORD_W-1:0] res_o,
    output logic              wr_o,
    output logic [3:0]        flags_o
);
    localparam int unsigned NWIDTH = 2;
    localparam int unsigned PAD_W  = WORD_W - BYTE_W;

    flag_t fin;
    flag_t fout;
    logic  legal;

    logic [WORD_W-1:0] r_w   [NWIDTH];
    logic              c_new [NWIDTH];
    logic              c_upd [NWIDTH];
    logic              v_new [NWIDTH];
    logic              v_upd [NWIDTH];

    assign fin = flag_t'(flags_i);

    sm_decode u_dec (
        .code_i  (code_i),
        .legal_o (legal),
        .wr_o    (wr_o)
    );

    // Lane 0 is the byte datapath, lane 1 the word datapath.
    for (genvar g = 0; g < NWIDTH; g++) begin : g_lane
        localparam int unsigned LW = (g == 0) ? BYTE_W : WORD_W;
        logic [LW-1:0] r_l;
        sm_core #(.W(LW)) u_core (
            .a_i     (opnd_i[LW-1:0]),
            .code_i  (code_i),
            .cin_i   (fin.c),
            .r_o     (r_l),
            .c_new_o (c_new[g]),
            .c_upd_o (c_upd[g]),
            .v_new_o (v_new[g]),
            .v_upd_o (v_upd[g])
        );
        if (g == 0) begin : g_pad
            assign r_w[g] = {{PAD_W{1'b0}}, r_l};
        end else begin : g_full
            assign r_w[g] = r_l;
        end
    end

    logic sel;
    assign sel   = word_i;
    assign res_o = legal ? r_w[sel] : '0;

    sm_flags u_flg (
        .legal_i (legal),
        .word_i  (word_i),
        .res_i   (res_o),
        .c_new_i (c_new[sel]),
        .c_upd_i (c_upd[sel]),
        .v_new_i (v_new[sel]),
        .v_upd_i (v_upd[sel]),
        .flags_i (fin),
        .flags_o (fout)
    );

    assign flags_o = fout;

    always_comb begin
        assert_no_store_illegal_R11: assert (legal || (!wr_o && flags_o == flags_i));
        assert_z_tracks_result_R1: assert (!legal || (flags_o[2] == (res_o == '0)));
        assert_byte_high_clear_R1: assert (word_i || (res_o[WORD_W-1:BYTE_W] == '0));
        assert_incdec_keep_c_R7: assert (!((code_i == OP_INC) || (code_i == OP_DEC))
                                         || (flags_o[1] == flags_i[1]));
        assert_clear_zero_R10: assert (code_i != OP_CLR
                                       || (res_o == '0 && flags_o[3:2] == 2'b01));
        assert_test_no_store_R8: assert (code_i != OP_TNZ || !wr_o);
    end
endmodule

// File: tb/sim_sm_unit.sv
`timescale 1ns/1ps
module sim_sm_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opnd = '0;
    logic [3:0]  code = '0;
    logic        word = 1'b0;
    logic [3:0]  fl_in = '0;
    logic [15:0] res;
    logic        wr;
    logic [3:0]  fl_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sm_unit u0 (
        .opnd_i  (opnd),
        .code_i  (code),
        .word_i  (word),
        .flags_i (fl_in),
        .res_o   (res),
        .wr_o    (wr),
        .flags_o (fl_out)
    );

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'h0: tag_of = "R2";
            4'h3: tag_of = "R3";
            4'h4, 4'h7: tag_of = "R4";
            4'h6, 4'h9: tag_of = "R5";
            4'h8: tag_of = "R6";
            4'hA, 4'hC: tag_of = "R7";
            4'hD: tag_of = "R8";
            4'hE: tag_of = "R9";
            4'hF: tag_of = "R10";
            default: tag_of = "R11";
        endcase
    endfunction

    // Returns {wr, N, Z, C, V, result[15:0]}
    function automatic logic [20:0] model(input logic [15:0] a, input logic [3:0] c,
                                          input logic w, input logic [3:0] f);
        int unsigned bits = w ? 16 : 8;
        int unsigned mask = w ? 32'hFFFF : 32'hFF;
        int unsigned msb  = w ? 32'h8000 : 32'h80;
        int unsigned x    = a & mask;
        int unsigned r    = 0;
        logic cc = f[1];
        logic vv = f[0];
        logic ok = 1'b1;
        logic we = 1'b1;
        case (c)
            4'h0: begin r = (0 - x) & mask; cc = (x != 0); vv = (x == msb); end
            4'h3: begin r = (~x) & mask; cc = 1'b1; end
            4'h4: begin r = x >> 1; cc = x[0]; end
            4'h7: begin r = (x >> 1) | (x & msb); cc = x[0]; end
            4'h6: begin r = (x >> 1) | (f[1] ? msb : 0); cc = x[0]; end
            4'h8: begin r = (x << 1) & mask; cc = ((x & msb) != 0); end
            4'h9: begin r = ((x << 1) & mask) | f[1]; cc = ((x & msb) != 0); end
            4'hA: begin r = (x - 1) & mask; vv = (x == msb); end
            4'hC: begin r = (x + 1) & mask; vv = (x == msb - 1); end
            4'hD: begin r = x; we = 1'b0; end
            4'hE: r = ((x << (bits/2)) | (x >> (bits/2))) & mask;
            4'hF: r = 0;
            default: begin ok = 1'b0; we = 1'b0; r = 0; end
        endcase
        if (ok) model = {we, ((r & msb) != 0), (r == 0), cc, vv, r[15:0]};
        else    model = {1'b0, f, 16'h0};
    endfunction

    task automatic apply(input logic [15:0] a, input logic [3:0] c,
                         input logic w, input logic [3:0] f);
        logic [20:0] exp;
        @(posedge clk);
        #1;
        opnd = a; code = c; word = w; fl_in = f;
        exp = model(a, c, w, f);
        @(negedge clk);
        checks++;
        if ({wr, fl_out, res} !== exp) begin
            errors++;
            $display("FAIL %s/%s code=%h word=%0d opnd=%h flags=%b: actual wr=%b flags=%b res=%h expected wr=%b flags=%b res=%h",
                     tag_of(c), w ? "R12" : "R1", c, w, a, f,
                     wr, fl_out, res, exp[20], exp[19:16], exp[15:0]);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7531));
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // initial state: all-zero inputs (negate of zero) R2, R1
        apply(16'h0000, 4'h0, 1'b0, 4'b0000);
        // R2 most negative operand
        apply(16'h0080, 4'h0, 1'b0, 4'b0000);
        apply(16'h8000, 4'h0, 1'b1, 4'b0000);
        // R3
        apply(16'h00A5, 4'h3, 1'b0, 4'b0001);
        // R4 shifts with sign bit set
        apply(16'h0081, 4'h4, 1'b0, 4'b0000);
        apply(16'h0081, 4'h7, 1'b0, 4'b0000);
        // R5 carry entering rotates
        apply(16'h0002, 4'h6, 1'b0, 4'b0010);
        apply(16'h4000, 4'h9, 1'b1, 4'b0010);
        // R6
        apply(16'h00C0, 4'h8, 1'b0, 4'b0000);
        // R7 overflow boundaries, carry kept
        apply(16'h007F, 4'hC, 1'b0, 4'b0010);
        apply(16'h0080, 4'hA, 1'b0, 4'b0010);
        apply(16'h0000, 4'hA, 1'b0, 4'b0000);
        apply(16'h7FFF, 4'hC, 1'b1, 4'b0000);
        // R8 test leaves carry/overflow
        apply(16'h0000, 4'hD, 1'b0, 4'b0011);
        // R9 nibble and byte swap
        apply(16'hFF5A, 4'hE, 1'b0, 4'b0000);
        apply(16'h1234, 4'hE, 1'b1, 4'b0000);
        // R10
        apply(16'hFFFF, 4'hF, 1'b1, 4'b1011);
        // R11 illegal codes pass flags through
        apply(16'h1234, 4'h1, 1'b0, 4'b1010);
        apply(16'h1234, 4'h2, 1'b1, 4'b0101);
        apply(16'hFFFF, 4'h5, 1'b0, 4'b1111);
        apply(16'h0000, 4'hB, 1'b1, 4'b0000);
        // R1 R12 random mix over all codes and both widths
        for (int i = 0; i < 3000; i++) begin
            apply(16'($urandom), 4'($urandom), 1'($urandom), 4'($urandom));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule